// File: doc/BRIEF.md
# Register-Port Stream Bridge

This block joins a simple register-style software port to two hardware streaming ports. A software write places a data word on a downstream path, and hardware takes it through a valid/ready handshake. Hardware offers words on an upstream path through its own valid/ready handshake, and a software read removes them. The two paths are independent. Each has its own depth parameter, and in each path words leave in the order they arrived.

A depth of zero turns a path into an unbuffered bypass that still uses handshakes. On the downstream side the bypass is a single staging register that holds one word until hardware takes it. On the upstream side a software read passes the hardware word straight through. Two parameters choose whether a read from an empty upstream path stalls and whether a write to a full downstream path stalls. A stall shows as a busy output. When a stall is not selected, a write to a full path is lost, and a read from an empty path returns the last word read without removing anything. Empty and full flags for both paths go to hardware. Address decoding and clock-domain crossing belong to the surrounding logic.

Top module: `csr_stream_bridge`

## Requirements
- R1: Downstream words appear on `hw_dn_data_o` in write order. `hw_dn_valid_o` is high whenever the path holds a word. A word that is not taken (valid high, ready low) stays unchanged on the next cycle.
- R2: When the downstream path is full, a software write in the same cycle as a hardware take (`hw_dn_ready_i` high) is accepted, and the path stays full.
- R3: `sw_wbusy_o` is high exactly when BLOCK_WR=1, the downstream path is full and hardware is not taking a word. A write in that state is not stored. With BLOCK_WR=0, `sw_wbusy_o` stays low and a write to a full path is discarded.
- R4: Upstream words are read back in push order. With DEPTH>0, `hw_up_ready_o` is high when the path is not full, or when a read pops a word in the same cycle.
- R5: While the upstream path holds a word, `sw_rdata_o` shows the oldest word, and a read (`sw_re_i` high) removes it. While the path is empty, `sw_rdata_o` shows the last word removed (0 after reset), and a read removes nothing.
- R6: `sw_rbusy_o` is high exactly when BLOCK_RD=1 and the upstream path is empty.
- R7: `hw_dn_empty_o`, `hw_dn_full_o`, `hw_up_empty_o` and `hw_up_full_o` report a held word count of 0 or of DEPTH for their path.
- R8: With DN_DEPTH=0, the downstream path holds one staged word. It reports full while that word is waiting and empty once hardware takes it.
- R9: With UP_DEPTH=0, `sw_rdata_o` passes `hw_up_data_i` through while `hw_up_valid_i` is high, and `hw_up_ready_o` follows `sw_re_i`. The empty flag is the inverse of `hw_up_valid_i`, and the full flag equals it.
- R10: A low level on `rst_ni` at once empties both paths, drops `hw_dn_valid_o`, and clears the last-read word to 0. It does not wait for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_wdata_i | input | DATA_W | Software write data |
| sw_we_i | input | 1 | Software write strobe |
| sw_re_i | input | 1 | Software read strobe |
| sw_rdata_o | output | DATA_W | Software read data |
| sw_rbusy_o | output | 1 | Read stalled |
| sw_wbusy_o | output | 1 | Write stalled |
| hw_up_valid_i | input | 1 | Upstream word offered by hardware |
| hw_up_data_i | input | DATA_W | Upstream word |
| hw_up_ready_o | output | 1 | Upstream word accepted |
| hw_up_empty_o | output | 1 | Upstream path empty |
| hw_up_full_o | output | 1 | Upstream path full |
| hw_dn_valid_o | output | 1 | Downstream word available |
| hw_dn_data_o | output | DATA_W | Downstream word |
| hw_dn_ready_i | input | 1 | Hardware takes downstream word |
| hw_dn_empty_o | output | 1 | Downstream path empty |
| hw_dn_full_o | output | 1 | Downstream path full |

## Verification
The bench builds two copies of the block. The first has depth 2 on both paths with both stall options on, so it reaches full and empty within a few words. That exposes the busy outputs, the push-and-pop case on a full path, and the return of the last word from an empty path. The second has depth 0 on both paths with both stall options off. It covers the staging register, the pass-through read, and a write that is discarded while the staged word waits. An asynchronous reset in the middle of traffic is applied to the first copy.

// File: rtl/csr_bridge_pkg.sv
package csr_bridge_pkg;

  function automatic int unsigned ptr_w(int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

  function automatic int unsigned cnt_w(int unsigned depth);
    return $clog2(depth + 1);
  endfunction

endpackage

// File: rtl/bridge_fifo.sv
module bridge_fifo
  import csr_bridge_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             empty_o,
  output logic             full_o
);

  localparam int unsigned PW = ptr_w(DEPTH);
  localparam int unsigned CW = cnt_w(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PW-1:0]    wptr_q, rptr_q;
  logic [CW-1:0]    cnt_q;

  function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) wptr_q <= bump(wptr_q);
      if (pop_i)  rptr_q <= bump(rptr_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wptr_q] <= wdata_i;
  end

  assign rdata_o = mem_q[rptr_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));

  assert_no_overflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && full_o |-> pop_i);
  assert_no_underflow_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  assert_count_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  assert_fills_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !pop_i && (cnt_q == CW'(DEPTH - 1)) |=> full_o);

endmodule

// File: rtl/bridge_dn_path.sv
module bridge_dn_path #(
  parameter int unsigned WIDTH    = 8,
  parameter int unsigned DEPTH    = 4,
  parameter bit          BLOCK_WR = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sw_we_i,
  input  logic [WIDTH-1:0] sw_wdata_i,
  output logic             sw_wbusy_o,
  output logic             hw_valid_o,
  output logic [WIDTH-1:0] hw_data_o,
  input  logic             hw_ready_i,
  output logic             empty_o,
  output logic             full_o
);

  // depth 0 keeps a single staging entry
  localparam int unsigned STORE = (DEPTH == 0) ? 1 : DEPTH;

  logic pop, push;

  assign pop  = hw_ready_i && !empty_o;
  assign push = sw_we_i && (!full_o || pop);

  bridge_fifo #(.WIDTH(WIDTH), .DEPTH(STORE)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .wdata_i (sw_wdata_i),
    .pop_i   (pop),
    .rdata_o (hw_data_o),
    .empty_o (empty_o),
    .full_o  (full_o)
  );

  assign hw_valid_o = !empty_o;

  generate
    if (BLOCK_WR) begin : g_block
      assign sw_wbusy_o = full_o && !pop;
    end else begin : g_drop
      assign sw_wbusy_o = 1'b0;
    end
  endgenerate

  assert_dn_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_valid_o && !hw_ready_i |=> hw_valid_o && $stable(hw_data_o));
  assert_busy_blocks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_wbusy_o && !hw_ready_i |=> full_o);

endmodule

// File: rtl/bridge_up_path.sv
module bridge_up_path #(
  parameter int unsigned WIDTH    = 8,
  parameter int unsigned DEPTH    = 4,
  parameter bit          BLOCK_RD = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hw_valid_i,
  input  logic [WIDTH-1:0] hw_data_i,
  output logic             hw_ready_o,
  input  logic             sw_re_i,
  output logic [WIDTH-1:0] sw_rdata_o,
  output logic             sw_rbusy_o,
  output logic             empty_o,
  output logic             full_o
);

  logic [WIDTH-1:0] head;
  logic [WIDTH-1:0] last_q;
  logic             pop;

  generate
    if (DEPTH == 0) begin : g_bypass
      assign head       = hw_data_i;
      assign empty_o    = !hw_valid_i;
      assign full_o     = hw_valid_i;
      assign hw_ready_o = sw_re_i;
      assign pop        = sw_re_i && hw_valid_i;
    end else begin : g_fifo
      logic push;
      assign pop        = sw_re_i && !empty_o;
      assign hw_ready_o = !full_o || pop;
      assign push       = hw_valid_i && hw_ready_o;

      bridge_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_fifo (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .push_i  (push),
        .wdata_i (hw_data_i),
        .pop_i   (pop),
        .rdata_o (head),
        .empty_o (empty_o),
        .full_o  (full_o)
      );

      assert_up_keep_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !empty_o && !sw_re_i |=> !empty_o);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  last_q <= '0;
    else if (pop) last_q <= head;
  end

  assign sw_rdata_o = empty_o ? last_q : head;
  assign sw_rbusy_o = BLOCK_RD && empty_o;

  assert_empty_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_re_i && empty_o |=> (sw_rdata_o == $past(sw_rdata_o)) || !empty_o);
  assert_busy_empty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rbusy_o |-> !pop);

endmodule

// File: rtl/csr_stream_bridge.sv
module csr_stream_bridge #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned DN_DEPTH = 4,
  parameter int unsigned UP_DEPTH = 4,
  parameter bit          BLOCK_RD = 1'b0,
  parameter bit          BLOCK_WR = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] sw_wdata_i,
  input  logic              sw_we_i,
  input  logic              sw_re_i,
  output logic [DATA_W-1:0] sw_rdata_o,
  output logic              sw_rbusy_o,
  output logic              sw_wbusy_o,
  input  logic              hw_up_valid_i,
  input  logic [DATA_W-1:0] hw_up_data_i,
  output logic              hw_up_ready_o,
  output logic              hw_up_empty_o,
  output logic              hw_up_full_o,
  output logic              hw_dn_valid_o,
  output logic [DATA_W-1:0] hw_dn_data_o,
  input  logic              hw_dn_ready_i,
  output logic              hw_dn_empty_o,
  output logic              hw_dn_full_o
);

  bridge_dn_path #(.WIDTH(DATA_W), .DEPTH(DN_DEPTH), .BLOCK_WR(BLOCK_WR)) u_dn (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sw_we_i    (sw_we_i),
    .sw_wdata_i (sw_wdata_i),
    .sw_wbusy_o (sw_wbusy_o),
    .hw_valid_o (hw_dn_valid_o),
    .hw_data_o  (hw_dn_data_o),
    .hw_ready_i (hw_dn_ready_i),
    .empty_o    (hw_dn_empty_o),
    .full_o     (hw_dn_full_o)
  );

  bridge_up_path #(.WIDTH(DATA_W), .DEPTH(UP_DEPTH), .BLOCK_RD(BLOCK_RD)) u_up (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hw_valid_i (hw_up_valid_i),
    .hw_data_i  (hw_up_data_i),
    .hw_ready_o (hw_up_ready_o),
    .sw_re_i    (sw_re_i),
    .sw_rdata_o (sw_rdata_o),
    .sw_rbusy_o (sw_rbusy_o),
    .empty_o    (hw_up_empty_o),
    .full_o     (hw_up_full_o)
  );

  assert_flags_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hw_dn_empty_o && hw_dn_full_o));
  assert_take_frees_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_dn_full_o && hw_dn_ready_i && !sw_we_i |=> !hw_dn_full_o);

endmodule

// File: tb/csr_stream_bridge_tb.sv
module csr_stream_bridge_tb;

  typedef struct packed {
    logic       we;
    logic [7:0] wd;
    logic       re;
    logic       uv;
    logic [7:0] ud;
    logic       dr;
    logic [7:0] e_rd;
    logic       e_rbusy;
    logic       e_wbusy;
    logic       e_dv;
    logic [7:0] e_dd;
    logic       e_ur;
    logic       e_dfull;
    logic       e_ufull;
  } vec_t;

  localparam int NV = 18;
  // depth 2 both paths, both stalls on; e_dd checked only when e_dv
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0},
    '{1'b1, 8'hA1, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0},
    '{1'b1, 8'hA2, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'hA1, 1'b1, 1'b0, 1'b0},
    '{1'b1, 8'hA3, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 8'hA1, 1'b1, 1'b1, 1'b0},
    '{1'b1, 8'hA3, 1'b0, 1'b0, 8'h00, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1, 8'hA1, 1'b1, 1'b1, 1'b0},
    '{1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1, 8'hA2, 1'b1, 1'b1, 1'b0},
    '{1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1, 8'hA3, 1'b1, 1'b0, 1'b0},
    '{1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0},
    '{1'b0, 8'h00, 1'b0, 1'b1, 8'hB1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0},
    '{1'b0, 8'h00, 1'b0, 1'b1, 8'hB2, 1'b0, 8'hB1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0},
    '{1'b0, 8'h00, 1'b0, 1'b1, 8'hB3, 1'b0, 8'hB1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1},
    '{1'b0, 8'h00, 1'b1, 1'b1, 8'hB3, 1'b0, 8'hB1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1},
    '{1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 8'hB2, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1},
    '{1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 8'hB3, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0},
    '{1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 8'hB3, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0},
    '{1'b1, 8'hC1, 1'b0, 1'b1, 8'hD1, 1'b1, 8'hB3, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0},
    '{1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1, 8'hD1, 1'b0, 1'b0, 1'b1, 8'hC1, 1'b1, 1'b0, 1'b0},
    '{1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 8'hD1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  // main copy
  logic [7:0] wd, ud, rd, dd;
  logic we, re, uv, dr;
  logic rbusy, wbusy, ur, ue, uf, dv, de, df;
  // bypass copy
  logic [7:0] b_wd, b_ud, b_rd, b_dd;
  logic b_we, b_re, b_uv, b_dr;
  logic b_rbusy, b_wbusy, b_ur, b_ue, b_uf, b_dv, b_de, b_df;

  csr_stream_bridge #(.DATA_W(8), .DN_DEPTH(2), .UP_DEPTH(2),
                      .BLOCK_RD(1'b1), .BLOCK_WR(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sw_wdata_i(wd), .sw_we_i(we), .sw_re_i(re),
    .sw_rdata_o(rd), .sw_rbusy_o(rbusy), .sw_wbusy_o(wbusy),
    .hw_up_valid_i(uv), .hw_up_data_i(ud), .hw_up_ready_o(ur),
    .hw_up_empty_o(ue), .hw_up_full_o(uf),
    .hw_dn_valid_o(dv), .hw_dn_data_o(dd), .hw_dn_ready_i(dr),
    .hw_dn_empty_o(de), .hw_dn_full_o(df));

  csr_stream_bridge #(.DATA_W(8), .DN_DEPTH(0), .UP_DEPTH(0),
                      .BLOCK_RD(1'b0), .BLOCK_WR(1'b0)) u_dut_byp (
    .clk_i(clk), .rst_ni(rst_n), .sw_wdata_i(b_wd), .sw_we_i(b_we), .sw_re_i(b_re),
    .sw_rdata_o(b_rd), .sw_rbusy_o(b_rbusy), .sw_wbusy_o(b_wbusy),
    .hw_up_valid_i(b_uv), .hw_up_data_i(b_ud), .hw_up_ready_o(b_ur),
    .hw_up_empty_o(b_ue), .hw_up_full_o(b_uf),
    .hw_dn_valid_o(b_dv), .hw_dn_data_o(b_dd), .hw_dn_ready_i(b_dr),
    .hw_dn_empty_o(b_de), .hw_dn_full_o(b_df));

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    {we, re, uv, dr, wd, ud} = '0;
    {b_we, b_re, b_uv, b_dr, b_wd, b_ud} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R10 reset dn_valid", {7'd0, dv}, 8'd0);
    check("R10 reset dn_empty", {7'd0, de}, 8'd1);
    check("R10 reset rdata", rd, 8'h00);
    check("R7 reset up_empty", {7'd0, ue}, 8'd1);

    // table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      we = VECS[i].we; wd = VECS[i].wd; re = VECS[i].re;
      uv = VECS[i].uv; ud = VECS[i].ud; dr = VECS[i].dr;
      #1;
      check($sformatf("R5 v%0d rdata", i), rd, VECS[i].e_rd);
      check($sformatf("R6 v%0d rbusy", i), {7'd0, rbusy}, {7'd0, VECS[i].e_rbusy});
      check($sformatf("R3 v%0d wbusy", i), {7'd0, wbusy}, {7'd0, VECS[i].e_wbusy});
      check($sformatf("R1 v%0d dn_valid", i), {7'd0, dv}, {7'd0, VECS[i].e_dv});
      if (VECS[i].e_dv)  // R2 covered by v4: push and take on full path
        check($sformatf("R1 v%0d dn_data", i), dd, VECS[i].e_dd);
      check($sformatf("R4 v%0d up_ready", i), {7'd0, ur}, {7'd0, VECS[i].e_ur});
      check($sformatf("R7 v%0d dn_full", i), {7'd0, df}, {7'd0, VECS[i].e_dfull});
      check($sformatf("R7 v%0d up_full", i), {7'd0, uf}, {7'd0, VECS[i].e_ufull});
    end

    // bypass copy: downstream staging register
    @(negedge clk);
    {we, re, uv, dr} = '0;
    b_we = 1'b1; b_wd = 8'hE1; b_dr = 1'b0;
    #1;
    check("R8 byp empty before write", {7'd0, b_de}, 8'd1);
    check("R3 byp wbusy nonblocking", {7'd0, b_wbusy}, 8'd0);
    @(negedge clk);
    b_wd = 8'hE2;
    #1;
    check("R8 byp staged valid", {7'd0, b_dv}, 8'd1);
    check("R8 byp staged full", {7'd0, b_df}, 8'd1);
    check("R3 byp wbusy while full", {7'd0, b_wbusy}, 8'd0);
    @(negedge clk);
    b_we = 1'b0; b_dr = 1'b1;
    #1;
    check("R3 byp second write dropped", b_dd, 8'hE1);
    @(negedge clk);
    b_dr = 1'b0;
    #1;
    check("R8 byp empty after take", {7'd0, b_de}, 8'd1);

    // bypass copy: upstream pass-through
    @(negedge clk);
    b_uv = 1'b1; b_ud = 8'hF1; b_re = 1'b0;
    #1;
    check("R9 byp up_ready follows read", {7'd0, b_ur}, 8'd0);
    check("R9 byp up_full", {7'd0, b_uf}, 8'd1);
    check("R9 byp pass-through", b_rd, 8'hF1);
    @(negedge clk);
    b_re = 1'b1;
    #1;
    check("R9 byp up_ready on read", {7'd0, b_ur}, 8'd1);
    @(negedge clk);
    b_uv = 1'b0; b_ud = 8'h33;
    #1;
    check("R9 byp up_empty", {7'd0, b_ue}, 8'd1);
    check("R5 byp last word held", b_rd, 8'hF1);
    check("R6 byp rbusy nonblocking", {7'd0, b_rbusy}, 8'd0);

    // async reset in the middle of traffic
    @(negedge clk);
    b_re = 1'b0;
    we = 1'b1; wd = 8'h77;
    @(negedge clk);
    we = 1'b0;
    #1;
    check("R1 pre-reset dn_valid", {7'd0, dv}, 8'd1);
    #1;
    rst_n = 1'b0;
    #1;
    check("R10 async dn_valid", {7'd0, dv}, 8'd0);
    check("R10 async dn_empty", {7'd0, de}, 8'd1);
    check("R10 async last cleared", rd, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check("R10 stays empty after release", {7'd0, dv}, 8'd0);

    summary();
    $finish;
  end

endmodule